// File: doc/BRIEF.md
# Two's Complement Add / Subtract / Negate Unit

A purely combinational arithmetic slice for two's complement integers. It takes two operands and a two-bit operation select. It returns the wrapped result, that result widened with its sign, the raw carry leaving the top bit of the adder, and an overflow flag.

All four operations share one carry-propagate adder. Each operation only changes what is fed into that adder:

| Operation | First adder input | Second adder input | Carry in |
|-----------|-------------------|--------------------|----------|
| add | operand A | operand B | 0 |
| subtract | operand A | inverted operand B | 1 |
| negate | inverted operand A | zero | 1 |
| pass | operand A | zero | 0 |

Overflow for add and subtract comes from comparing the signs of the two adder inputs with the sign of the sum. Overflow for negate is raised when a nonzero operand keeps its sign after negation. That happens only for the most negative value, which maps back onto itself.

Operand width and widened width are parameters. The defaults are 8 and 16. A further parameter chooses between an explicit ripple chain and an inferred adder.

Top module: `ts_arith_unit`

## Requirements
- R1: With op_code 00 (add), result equals (A + B) mod 2^8 and carry_out equals bit 8 of the unsigned sum A + B.
- R2: With op_code 01 (subtract A minus B), result equals (A - B) mod 2^8 and carry_out is 1 exactly when unsigned A >= unsigned B (no borrow).
- R3: With op_code 00, overflow is 1 exactly when A and B have equal bit 7 and result bit 7 differs from it, that is when the signed sum leaves -128..+127.
- R4: With op_code 01, overflow is 1 exactly when the signed difference A - B leaves -128..+127.
- R5: With op_code 10 (negate A), result equals (0 - A) mod 2^8 and carry_out is 1 exactly when A is zero.
- R6: With op_code 10, overflow is 1 only for A = 8'h80, whose result is 8'h80 again; negating zero gives zero with overflow 0.
- R7: With op_code 11 (pass A), result equals A, and carry_out and overflow are both 0.
- R8: result_wide bits 7..0 equal result, and bits 15..8 are all copies of result bit 7.
- R9: With op_code 10 or 11, operand B has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 2 | Operation select: 00 add, 01 subtract, 10 negate A, 11 pass A |
| opnd_a | input | 8 | First operand, two's complement |
| opnd_b | input | 8 | Second operand, two's complement |
| result | output | 8 | Wrapped arithmetic result |
| result_wide | output | 16 | result widened by replicating its sign bit |
| carry_out | output | 1 | Raw carry out of the adder's top bit |
| overflow | output | 1 | Signed overflow of the selected operation |

## Verification
Carry and signed overflow are separate functions, and both can be raised by the same operand pair. One example is adding 8'h80 to 8'h80, which gives zero with carry 1 and overflow 1. Another is subtracting a positive value from a negative one past the range.

The operand sweep covers every add and subtract pair, so every combination of carry and overflow is hit. Each flag is compared on its own against integer arithmetic on each vector. Negation of 8'h80 and of zero covers the case where the carry and overflow flags disagree at the range edges.

// File: rtl/ts_arith_pkg.sv
package ts_arith_pkg;

   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_SUB  = 2'b01,
      OP_NEG  = 2'b10,
      OP_PASS = 2'b11
   } ts_op_e;

   localparam int ADDER_RIPPLE   = 0;
   localparam int ADDER_INFERRED = 1;

endpackage

// File: rtl/ts_operand_prep.sv
module ts_operand_prep
   import ts_arith_pkg::*;
#(
   parameter int W = 8
) (
   input  ts_op_e         op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   x,
   output logic [W-1:0]   y,
   output logic           cin
);

   // Every operation is mapped onto a single add: x + y + cin.
   always_comb begin
      x   = a;
      y   = '0;
      cin = 1'b0;
      unique case (op)
         OP_ADD: begin
            y = b;
         end
         OP_SUB: begin
            y   = ~b;
            cin = 1'b1;
         end
         OP_NEG: begin
            x   = ~a;
            cin = 1'b1;
         end
         OP_PASS: begin
            x = a;
         end
         default: begin
            x = a;
         end
      endcase
   end

endmodule

// File: rtl/ts_adder.sv
module ts_adder
   import ts_arith_pkg::*;
#(
   parameter int W    = 8,
   parameter int KIND = ADDER_RIPPLE
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);

   generate
      if (KIND == ADDER_RIPPLE) begin : g_ripple
         logic [W:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]   = x[i] ^ y[i] ^ c[i];
            assign c[i+1]   = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
         end
         assign cout = c[W];
      end else if (KIND == ADDER_INFERRED) begin : g_inferred
         logic [W:0] full;
         assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
         assign sum  = full[W-1:0];
         assign cout = full[W];
      end else begin : g_bad_kind
         $error("ts_adder: unsupported KIND %0d", KIND);
      end
   endgenerate

endmodule

// File: rtl/ts_ovf_detect.sv
module ts_ovf_detect
   import ts_arith_pkg::*;
(
   input  ts_op_e op,
   input  logic   x_msb,
   input  logic   y_msb,
   input  logic   a_msb,
   input  logic   a_zero,
   input  logic   sum_msb,
   output logic   ovf
);

   logic same_in_sign;
   logic sign_flipped;

   assign same_in_sign = ~(x_msb ^ y_msb);
   assign sign_flipped = sum_msb ^ x_msb;

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB: ovf = same_in_sign & sign_flipped;
         // Negation of a nonzero value must flip the sign; if it does not,
         // the operand was the most negative code.
         OP_NEG:         ovf = ~a_zero & ~(a_msb ^ sum_msb);
         OP_PASS:        ovf = 1'b0;
         default:        ovf = 1'b0;
      endcase
   end

endmodule

// File: rtl/ts_sign_widen.sv
module ts_sign_widen #(
   parameter int W  = 8,
   parameter int EW = 16
) (
   input  logic [W-1:0]  narrow,
   output logic [EW-1:0] wide
);

   assign wide[W-1:0] = narrow;

   generate
      for (genvar i = W; i < EW; i++) begin : g_ext
         assign wide[i] = narrow[W-1];
      end
   endgenerate

endmodule

// File: rtl/ts_arith_unit.sv
module ts_arith_unit
   import ts_arith_pkg::*;
#(
   parameter int W          = 8,
   parameter int EW         = 16,
   parameter int ADDER_KIND = ADDER_RIPPLE
) (
   input  logic [1:0]    op_code,
   input  logic [W-1:0]  opnd_a,
   input  logic [W-1:0]  opnd_b,
   output logic [W-1:0]  result,
   output logic [EW-1:0] result_wide,
   output logic          carry_out,
   output logic          overflow
);

   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_chk_w
         $error("ts_arith_unit: W must be at least 2");
      end
      if (EW < W) begin : g_chk_ew
         $error("ts_arith_unit: EW must not be below W");
      end
   endgenerate

   ts_op_e        op;
   logic [W-1:0]  x_in;
   logic [W-1:0]  y_in;
   logic          c_in;
   logic [W-1:0]  sum;
   logic          a_zero;

   assign op     = ts_op_e'(op_code);
   assign a_zero = ~|opnd_a;

   ts_operand_prep #(.W(W)) u_prep (
      .op  (op),
      .a   (opnd_a),
      .b   (opnd_b),
      .x   (x_in),
      .y   (y_in),
      .cin (c_in)
   );

   ts_adder #(.W(W), .KIND(ADDER_KIND)) u_add (
      .x    (x_in),
      .y    (y_in),
      .cin  (c_in),
      .sum  (sum),
      .cout (carry_out)
   );

   ts_ovf_detect u_ovf (
      .op      (op),
      .x_msb   (x_in[MSB]),
      .y_msb   (y_in[MSB]),
      .a_msb   (opnd_a[MSB]),
      .a_zero  (a_zero),
      .sum_msb (sum[MSB]),
      .ovf     (overflow)
   );

   ts_sign_widen #(.W(W), .EW(EW)) u_widen (
      .narrow (sum),
      .wide   (result_wide)
   );

   assign result = sum;

endmodule

// File: rtl/ts_arith_checks.sv
module ts_arith_checks #(
   parameter int W  = 8,
   parameter int EW = 16
) (
   input logic [1:0]    op_code,
   input logic [W-1:0]  opnd_a,
   input logic [W-1:0]  opnd_b,
   input logic [W-1:0]  result,
   input logic [EW-1:0] result_wide,
   input logic          carry_out,
   input logic          overflow
);

   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   always_comb begin
      // R3: add overflow only when like-signed operands give an unlike-signed result
      if (op_code == 2'b00) begin
         a_r3_add_overflow: assert (overflow ==
            ((opnd_a[W-1] == opnd_b[W-1]) && (result[W-1] != opnd_a[W-1])));
      end
      // R4: subtract overflow needs operands of different sign
      if (op_code == 2'b01 && overflow) begin
         a_r4_sub_sign_mix: assert (opnd_a[W-1] != opnd_b[W-1]);
      end
      // R6: most negative value negates to itself with overflow
      if (op_code == 2'b10 && opnd_a == MOST_NEG) begin
         a_r6_neg_min: assert (result == MOST_NEG && overflow);
      end
      // R5: zero negates to zero, with carry and no overflow
      if (op_code == 2'b10 && opnd_a == '0) begin
         a_r5_neg_zero: assert (result == '0 && carry_out && !overflow);
      end
      // R7: pass leaves A and raises no flag
      if (op_code == 2'b11) begin
         a_r7_pass: assert (result == opnd_a && !carry_out && !overflow);
      end
      // R8: widened output agrees with narrow result and its sign
      a_r8_widen: assert (result_wide[W-1:0] == result &&
                          result_wide[EW-1] == result[W-1]);
   end

endmodule

bind ts_arith_unit ts_arith_checks #(.W(W), .EW(EW)) u_chk (
   .op_code     (op_code),
   .opnd_a      (opnd_a),
   .opnd_b      (opnd_b),
   .result      (result),
   .result_wide (result_wide),
   .carry_out   (carry_out),
   .overflow    (overflow)
);

// File: tb/sim_ts_arith_unit.sv
`timescale 1ns/1ps
module sim_ts_arith_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  op_code = 2'b00;
   logic [7:0]  opnd_a = 8'h00;
   logic [7:0]  opnd_b = 8'h00;
   logic [7:0]  result;
   logic [15:0] result_wide;
   logic        carry_out;
   logic        overflow;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ts_arith_unit u0 (
      .op_code     (op_code),
      .opnd_a      (opnd_a),
      .opnd_b      (opnd_b),
      .result      (result),
      .result_wide (result_wide),
      .carry_out   (carry_out),
      .overflow    (overflow)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired actual=%0d cycles expected<=190000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s op=%0d a=%02h b=%02h actual=%0h expected=%0h",
                  tag, what, op_code, opnd_a, opnd_b, act, exp);
      end
   endtask

   // Behavioural reference built from integer arithmetic.
   task automatic run(input int op, input int a, input int b);
      int sa, sb, s, res, cy, ov, wide, sv;
      string tr, to;
      @(posedge clk);
      #1;
      op_code = op[1:0];
      opnd_a  = a[7:0];
      opnd_b  = b[7:0];
      sa = (a >= 128) ? a - 256 : a;
      sb = (b >= 128) ? b - 256 : b;
      case (op)
         0: begin s = a + b;             sv = sa + sb; tr = "R1"; to = "R3"; end
         1: begin s = a + (255 - b) + 1; sv = sa - sb; tr = "R2"; to = "R4"; end
         2: begin s = (255 - a) + 1;     sv = -sa;     tr = "R5"; to = "R6"; end
         default: begin s = a;           sv = sa;      tr = "R7"; to = "R7"; end
      endcase
      res  = s % 256;
      cy   = s / 256;
      ov   = (sv > 127 || sv < -128) ? 1 : 0;
      wide = (res >= 128) ? res + 65280 : res;
      @(negedge clk);
      chk(tr, "result", int'(result), res);
      chk(tr, "carry", int'(carry_out), cy);
      chk(to, "overflow", int'(overflow), ov);
      chk("R8", "wide", int'(result_wide), wide);
      if (op >= 2) begin
         // R9: B driven with a non-zero pattern; outputs must still match the B-free model
         chk("R9", "b_ignored", int'({result, carry_out, overflow}), (res * 4) + (cy * 2) + ov);
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // Start-up state with all-zero inputs: add of zeros
      chk("R1", "init_result", int'(result), 0);
      chk("R8", "init_wide", int'(result_wide), 0);
      chk("R3", "init_ovf", int'(overflow), 0);

      // Edge cases called out in the requirements
      run(2, 8'h80, 8'h00);      // R6 most negative
      run(2, 8'h00, 8'hFF);      // R5/R6 zero
      run(0, 8'h80, 8'h80);      // R1/R3 carry and overflow together
      run(1, 8'h7F, 8'hFF);      // R4 positive overflow
      run(1, 8'h00, 8'h01);      // R2 borrow

      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            run(0, a, b);
            run(1, a, b);
         end
      end
      for (int a = 0; a < 256; a++) begin
         run(2, a, (a * 37 + 11) % 256);
         run(3, a, 255 - a);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule